// File: doc/BRIEF.md
# UART Interrupt Mask and Status Register Set

This block is the interrupt front end of a serial port. It keeps a mask of which event sources may raise an interrupt, a sticky record of events that have occurred while enabled, and a single interrupt line for the processor. Software changes the mask without a read-modify-write. A write of ones to the enable location switches the chosen bits on. A write of ones to the disable location switches them off. The mask itself can be read at its own location.

Event sources deliver one-cycle pulses, and each enabled pulse sets its status bit. Software clears a status bit by writing a one to it. A separate location shows the live condition levels (FIFO empty, full and the like), whatever the mask holds, so polled software can see them. The read bus is combinational: the read data follows the address in the same cycle.

Top module: `uirq_regs`

## Requirements
- R1: After reset the mask and the status register are all zero and the interrupt output is low.
- R2: A write to the enable location (offset 0x08) sets every mask bit whose write-data bit is 1. Mask bits whose write-data bit is 0 keep their value.
- R3: A write to the disable location (offset 0x0C) clears every mask bit whose write-data bit is 1. Mask bits whose write-data bit is 0 keep their value.
- R4: Reads of the enable and disable locations return 0. The mask is read at offset 0x10, and writes to that location do not change it.
- R5: A status bit (offset 0x14) becomes set only when its event pulse arrives in a cycle where its mask bit is already set. Pulses on masked-off bits leave the status unchanged.
- R6: Writing 1 to a status bit clears it and writing 0 leaves it. If an event pulse and a clearing write hit the same bit in the same cycle, the bit stays set.
- R7: The interrupt output is high exactly when some status bit and its mask bit are both set. Clearing a mask bit leaves its status bit latched but removes it from the interrupt.
- R8: The raw condition location (offset 0x2C) returns the live level inputs, independent of the mask. Writes to it have no effect.
- R9: Event bit positions are 0 rx trigger, 1 rx empty, 2 rx full, 3 tx empty, 4 tx full, 5 overrun, 6 framing, 7 parity, 8 rx timeout, and 9 to 12 spare. Bits 13 and up read as 0 and ignore writes, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the addressed location |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| evt_pulse | input | EVT_W | One-cycle event pulses, one per event bit |
| cond_lvl | input | EVT_W | Live condition levels shown at the raw location |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: 13 event bits on a 32-bit data word with 8-bit offsets. A 32-bit word leaves 19 bits above the event field. The bench writes all ones there and checks that they neither reach the mask or status nor read back. All 13 event bits take pulses at once, so masked and unmasked bits are exercised in the same cycle. The same-cycle clear-and-event race and the case of a latched bit whose mask was later removed are both driven at the ports.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

   typedef enum logic [2:0] {
      SEL_NONE = 3'd0,
      SEL_EN   = 3'd1,
      SEL_DIS  = 3'd2,
      SEL_MASK = 3'd3,
      SEL_STAT = 3'd4,
      SEL_RAW  = 3'd5
   } uirq_sel_e;

   localparam int unsigned DEF_ADDR_W = 8;
   localparam int unsigned DEF_DATA_W = 32;
   localparam int unsigned DEF_EVT_W  = 13;

   localparam logic [7:0] DEF_OFS_EN   = 8'h08;
   localparam logic [7:0] DEF_OFS_DIS  = 8'h0C;
   localparam logic [7:0] DEF_OFS_MASK = 8'h10;
   localparam logic [7:0] DEF_OFS_STAT = 8'h14;
   localparam logic [7:0] DEF_OFS_RAW  = 8'h2C;

endpackage

// File: rtl/uirq_decode.sv
module uirq_decode
   import uirq_pkg::*;
#(
   parameter int unsigned ADDR_W   = DEF_ADDR_W,
   parameter logic [ADDR_W-1:0] OFS_EN   = ADDR_W'(DEF_OFS_EN),
   parameter logic [ADDR_W-1:0] OFS_DIS  = ADDR_W'(DEF_OFS_DIS),
   parameter logic [ADDR_W-1:0] OFS_MASK = ADDR_W'(DEF_OFS_MASK),
   parameter logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(DEF_OFS_STAT),
   parameter logic [ADDR_W-1:0] OFS_RAW  = ADDR_W'(DEF_OFS_RAW)
) (
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   output uirq_sel_e         sel,
   output logic              set_we,
   output logic              clr_we,
   output logic              ack_we
);

   always_comb begin
      sel = SEL_NONE;
      if (addr == OFS_EN)        sel = SEL_EN;
      else if (addr == OFS_DIS)  sel = SEL_DIS;
      else if (addr == OFS_MASK) sel = SEL_MASK;
      else if (addr == OFS_STAT) sel = SEL_STAT;
      else if (addr == OFS_RAW)  sel = SEL_RAW;
   end

   assign set_we = wr && (sel == SEL_EN);
   assign clr_we = wr && (sel == SEL_DIS);
   assign ack_we = wr && (sel == SEL_STAT);

endmodule

// File: rtl/uirq_mask.sv
module uirq_mask #(
   parameter int unsigned EVT_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_we,
   input  logic             clr_we,
   input  logic [EVT_W-1:0] bits,
   output logic [EVT_W-1:0] mask
);

   logic [EVT_W-1:0] mask_q;
   logic [EVT_W-1:0] set_v;
   logic [EVT_W-1:0] clr_v;

   assign set_v = set_we ? bits : '0;
   assign clr_v = clr_we ? bits : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) mask_q <= '0;
      else        mask_q <= (mask_q | set_v) & ~clr_v;
   end

   assign mask = mask_q;

endmodule

// File: rtl/uirq_status.sv
module uirq_status #(
   parameter int unsigned EVT_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ack_we,
   input  logic [EVT_W-1:0] bits,
   input  logic [EVT_W-1:0] evt,
   input  logic [EVT_W-1:0] mask,
   output logic [EVT_W-1:0] stat
);

   for (genvar i = 0; i < EVT_W; i++) begin : g_cell
      logic hit;
      logic ack;
      logic q;

      assign hit = evt[i] & mask[i];
      assign ack = ack_we & bits[i];

      always_ff @(posedge clk) begin
         if (!rst_n)   q <= 1'b0;
         else if (hit) q <= 1'b1;
         else if (ack) q <= 1'b0;
      end

      assign stat[i] = q;
   end

endmodule

// File: rtl/uirq_rdmux.sv
module uirq_rdmux
   import uirq_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned EVT_W  = 13
) (
   input  uirq_sel_e         sel,
   input  logic [EVT_W-1:0]  mask,
   input  logic [EVT_W-1:0]  stat,
   input  logic [EVT_W-1:0]  lvl,
   output logic [DATA_W-1:0] rdata
);

   logic [EVT_W-1:0] field;

   always_comb begin
      case (sel)
         SEL_MASK: field = mask;
         SEL_STAT: field = stat;
         SEL_RAW:  field = lvl;
         default:  field = '0;
      endcase
   end

   if (DATA_W > EVT_W) begin : g_pad
      assign rdata = {{(DATA_W-EVT_W){1'b0}}, field};
   end else begin : g_full
      assign rdata = field;
   end

endmodule

// File: rtl/uirq_regs.sv
module uirq_regs
   import uirq_pkg::*;
#(
   parameter int unsigned ADDR_W = DEF_ADDR_W,
   parameter int unsigned DATA_W = DEF_DATA_W,
   parameter int unsigned EVT_W  = DEF_EVT_W,
   parameter logic [ADDR_W-1:0] OFS_EN   = ADDR_W'(DEF_OFS_EN),
   parameter logic [ADDR_W-1:0] OFS_DIS  = ADDR_W'(DEF_OFS_DIS),
   parameter logic [ADDR_W-1:0] OFS_MASK = ADDR_W'(DEF_OFS_MASK),
   parameter logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(DEF_OFS_STAT),
   parameter logic [ADDR_W-1:0] OFS_RAW  = ADDR_W'(DEF_OFS_RAW)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [EVT_W-1:0]  evt_pulse,
   input  logic [EVT_W-1:0]  cond_lvl,
   output logic              irq
);

   localparam int unsigned FIELD_W = EVT_W;

   if (EVT_W < 1) begin : g_bad_evt
      $error("uirq_regs: EVT_W must be at least 1");
   end
   if (EVT_W >= DATA_W) begin : g_bad_data
      $error("uirq_regs: DATA_W must exceed EVT_W");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("uirq_regs: ADDR_W too narrow for the offsets");
   end

   uirq_sel_e          sel;
   logic               set_we;
   logic               clr_we;
   logic               ack_we;
   logic [FIELD_W-1:0] wbits;
   logic [FIELD_W-1:0] mask_q;
   logic [FIELD_W-1:0] stat_q;

   assign wbits = bus_wdata[FIELD_W-1:0];

   uirq_decode #(
      .ADDR_W(ADDR_W), .OFS_EN(OFS_EN), .OFS_DIS(OFS_DIS),
      .OFS_MASK(OFS_MASK), .OFS_STAT(OFS_STAT), .OFS_RAW(OFS_RAW)
   ) u_dec (
      .wr(bus_wr), .addr(bus_addr), .sel(sel),
      .set_we(set_we), .clr_we(clr_we), .ack_we(ack_we)
   );

   uirq_mask #(.EVT_W(FIELD_W)) u_mask (
      .clk(clk), .rst_n(rst_n), .set_we(set_we), .clr_we(clr_we),
      .bits(wbits), .mask(mask_q)
   );

   uirq_status #(.EVT_W(FIELD_W)) u_stat (
      .clk(clk), .rst_n(rst_n), .ack_we(ack_we), .bits(wbits),
      .evt(evt_pulse), .mask(mask_q), .stat(stat_q)
   );

   uirq_rdmux #(.DATA_W(DATA_W), .EVT_W(FIELD_W)) u_rd (
      .sel(sel), .mask(mask_q), .stat(stat_q), .lvl(cond_lvl),
      .rdata(bus_rdata)
   );

   assign irq = |(stat_q & mask_q);

endmodule

// File: rtl/uirq_regs_chk.sv
module uirq_regs_chk #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned EVT_W  = 13,
   parameter logic [ADDR_W-1:0] OFS_EN   = 8'h08,
   parameter logic [ADDR_W-1:0] OFS_DIS  = 8'h0C,
   parameter logic [ADDR_W-1:0] OFS_RAW  = 8'h2C
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [EVT_W-1:0]  evt_pulse,
   input logic [EVT_W-1:0]  cond_lvl,
   input logic              irq,
   input logic [EVT_W-1:0]  mask,
   input logic [EVT_W-1:0]  stat
);

   assert_enable_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == OFS_EN) |=>
         ((mask & $past(bus_wdata[EVT_W-1:0])) == $past(bus_wdata[EVT_W-1:0])));

   assert_disable_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == OFS_DIS) |=>
         ((mask & $past(bus_wdata[EVT_W-1:0])) == '0));

   assert_split_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == OFS_EN || bus_addr == OFS_DIS) |-> (bus_rdata == '0));

   assert_set_needs_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat & ~$past(stat) & ~$past(evt_pulse & mask)) == '0));

   assert_event_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(evt_pulse & mask) & ~stat) == '0));

   assert_irq_has_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ((stat & mask) != '0));

   assert_raw_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == OFS_RAW) |-> (bus_rdata[EVT_W-1:0] == cond_lvl));

   assert_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[DATA_W-1:EVT_W] == '0);

endmodule

bind uirq_regs uirq_regs_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EVT_W(EVT_W),
   .OFS_EN(OFS_EN), .OFS_DIS(OFS_DIS), .OFS_RAW(OFS_RAW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse),
   .cond_lvl(cond_lvl), .irq(irq), .mask(mask_q), .stat(stat_q)
);

// File: tb/uirq_regs_test.sv
module uirq_regs_test;

   localparam int unsigned AW = 8;
   localparam int unsigned DW = 32;
   localparam int unsigned EW = 13;

   localparam logic [7:0] A_EN = 8'h08, A_DIS = 8'h0C, A_MSK = 8'h10,
                          A_STA = 8'h14, A_RAW = 8'h2C, A_NUL = 8'h00;

   typedef struct packed {
      logic        rd;
      logic [7:0]  addr;
      logic [31:0] data;
      logic [12:0] evt;
      logic [12:0] lvl;
      logic [31:0] exp;
      logic        xirq;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 30;
   localparam vec_t VEC [NV] = '{
      // R1 reset state
      '{1'b1, A_MSK, 32'h0, 13'h0, 13'h0, 32'h0, 1'b0, 4'd1},
      '{1'b1, A_STA, 32'h0, 13'h0, 13'h0, 32'h0, 1'b0, 4'd1},
      // R2 enable bits 0,2,8
      '{1'b0, A_EN,  32'h105, 13'h0, 13'h0, 32'h0, 1'b0, 4'd2},
      '{1'b1, A_MSK, 32'h0, 13'h0, 13'h0, 32'h105, 1'b0, 4'd2},
      // R4 split locations read zero
      '{1'b1, A_EN,  32'h0, 13'h0, 13'h0, 32'h0, 1'b0, 4'd4},
      '{1'b1, A_DIS, 32'h0, 13'h0, 13'h0, 32'h0, 1'b0, 4'd4},
      // R3 disable bit 2
      '{1'b0, A_DIS, 32'h004, 13'h0, 13'h0, 32'h0, 1'b0, 4'd3},
      '{1'b1, A_MSK, 32'h0, 13'h0, 13'h0, 32'h101, 1'b0, 4'd3},
      // R5 all events pulse, only bits 0 and 8 latch
      '{1'b0, A_NUL, 32'h0, 13'h1FFF, 13'h0, 32'h0, 1'b0, 4'd5},
      '{1'b1, A_STA, 32'h0, 13'h0, 13'h0, 32'h101, 1'b1, 4'd5},
      // R6 write-1 clear of bit 0, zeros leave bit 8
      '{1'b0, A_STA, 32'h001, 13'h0, 13'h0, 32'h0, 1'b0, 4'd6},
      '{1'b1, A_STA, 32'h0, 13'h0, 13'h0, 32'h100, 1'b1, 4'd6},
      // R6 clear and event on bit 8 in the same cycle: stays set
      '{1'b0, A_STA, 32'h100, 13'h100, 13'h0, 32'h0, 1'b0, 4'd6},
      '{1'b1, A_STA, 32'h0, 13'h0, 13'h0, 32'h100, 1'b1, 4'd6},
      // R7 masking bit 8 keeps status but drops the interrupt
      '{1'b0, A_DIS, 32'h100, 13'h0, 13'h0, 32'h0, 1'b0, 4'd7},
      '{1'b1, A_STA, 32'h0, 13'h0, 13'h0, 32'h100, 1'b0, 4'd7},
      // R7 re-enable brings the latched bit back to the interrupt
      '{1'b0, A_EN,  32'h100, 13'h0, 13'h0, 32'h0, 1'b0, 4'd7},
      '{1'b1, A_STA, 32'h0, 13'h0, 13'h0, 32'h100, 1'b1, 4'd7},
      // R8 raw levels regardless of mask, writes ignored
      '{1'b1, A_RAW, 32'h0, 13'h0, 13'h0AAA, 32'h0AAA, 1'b1, 4'd8},
      '{1'b0, A_RAW, 32'hFFFF, 13'h0, 13'h1555, 32'h0, 1'b0, 4'd8},
      '{1'b1, A_RAW, 32'h0, 13'h0, 13'h1555, 32'h1555, 1'b1, 4'd8},
      // R9 upper write-data bits ignored
      '{1'b0, A_EN,  32'hFFFF_FFFF, 13'h0, 13'h0, 32'h0, 1'b0, 4'd9},
      '{1'b1, A_MSK, 32'h0, 13'h0, 13'h0, 32'h1FFF, 1'b1, 4'd9},
      // R4 write to the mask location is ignored
      '{1'b0, A_MSK, 32'h0, 13'h0, 13'h0, 32'h0, 1'b0, 4'd4},
      '{1'b1, A_MSK, 32'h0, 13'h0, 13'h0, 32'h1FFF, 1'b1, 4'd4},
      // R9 unmapped offset reads zero
      '{1'b1, A_NUL, 32'h0, 13'h0, 13'h1FFF, 32'h0, 1'b1, 4'd9},
      // R5 all events with full mask
      '{1'b0, A_NUL, 32'h0, 13'h1FFF, 13'h0, 32'h0, 1'b0, 4'd5},
      '{1'b1, A_STA, 32'h0, 13'h0, 13'h0, 32'h1FFF, 1'b1, 4'd5},
      // R6 clear everything
      '{1'b0, A_STA, 32'hFFFF_FFFF, 13'h0, 13'h0, 32'h0, 1'b0, 4'd6},
      '{1'b1, A_STA, 32'h0, 13'h0, 13'h0, 32'h0, 1'b0, 4'd6}
   };

   logic          clk = 1'b0;
   logic          rst_n;
   logic          bus_wr;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata;
   logic [DW-1:0] bus_rdata;
   logic [EW-1:0] evt_pulse;
   logic [EW-1:0] cond_lvl;
   logic          irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   uirq_regs uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pulse(evt_pulse),
      .cond_lvl(cond_lvl), .irq(irq)
   );

   task automatic check(input logic [31:0] act, input logic [31:0] exp,
                        input int req, input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic do_write(input logic [7:0] a, input logic [31:0] d,
                           input logic [12:0] e);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d; evt_pulse = e;
      @(posedge clk);
      #1;
      bus_wr = 1'b0; evt_pulse = '0;
   endtask

   task automatic do_read(input logic [7:0] a, input logic [12:0] l,
                          input logic [31:0] exp, input logic xirq,
                          input int req);
      @(negedge clk);
      bus_addr = a; cond_lvl = l;
      #1;
      check(bus_rdata, exp, req, "read data");
      check({31'b0, irq}, {31'b0, xirq}, req, "irq");
   endtask

   initial begin
      rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
      evt_pulse = '0; cond_lvl = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         if (VEC[i].rd)
            do_read(VEC[i].addr, VEC[i].lvl, VEC[i].exp, VEC[i].xirq,
                    int'(VEC[i].req));
         else
            do_write(VEC[i].addr, VEC[i].data, VEC[i].evt);
      end

      // R1 reset in mid-run clears mask and status
      do_write(A_EN, 32'h1FFF, 13'h1FFF);
      @(negedge clk); rst_n = 1'b0;
      @(posedge clk); #1 rst_n = 1'b1;
      do_read(A_MSK, 13'h0, 32'h0, 1'b0, 1);
      do_read(A_STA, 13'h0, 32'h0, 1'b0, 1);

      // R5 events with an empty mask leave status clear
      do_write(A_NUL, 32'h0, 13'h1FFF);
      do_read(A_STA, 13'h0, 32'h0, 1'b0, 5);

      // R5 event in the same cycle as its enable write does not latch
      do_write(A_EN, 32'h008, 13'h008);
      do_read(A_STA, 13'h0, 32'h0, 1'b0, 5);
      do_read(A_MSK, 13'h0, 32'h008, 1'b0, 2);

      // R3 disable with zeros leaves the mask alone
      do_write(A_DIS, 32'h0, 13'h0);
      do_read(A_MSK, 13'h0, 32'h008, 1'b0, 3);

      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 5000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL R1 watchdog: actual timeout expected completion");
      end
      $display("End of test - %0d assertions evaluated, %0d failures",
               checks, fails);
      $finish;
   end

endmodule